// File: doc/BRIEF.md
# AXI-Stream Dual-Clock FIFO

This block carries AXI-Stream beats from one clock domain to another. A beat accepted on the receive-side slave port is stored as one word holding TDATA, TUSER, TKEEP and TLAST. It reappears, in arrival order, on the transmit-side master port, which runs on an unrelated clock. Each side has its own clock and its own active-high synchronous reset. Write and read pointers cross between the domains in Gray code through two-flop synchronizers. Each side derives its fill level from its own pointer and the synchronized copy of the other one.

Both stream ports follow valid/ready rules. A beat moves only on a rising edge where TVALID and TREADY are both high. The receive side holds `s_axis_tready` low while the storage array is full, which back-pressures the source. The sender must then keep its beat stable until it is taken. On the transmit side a beat that is offered but not taken stays valid with unchanged contents.

Two build-time choices shape the transmit port. In fall-through mode the oldest beat is presented without a request. An optional output register can then sit in front of the port. In request mode a beat is fetched into a register on a cycle where `m_axis_tready` is high, and it is shown on the next cycle. Each side also gives a plain fill count and a threshold flag, almost-full on the receive side and almost-empty on the transmit side.

Top module: `axis_cdc_fifo`

## Requirements
- R1: DEPTH is a power of two, at least 2. TKEEP is DATA_W/8 bits wide. Every beat leaves with the TDATA, TUSER, TKEEP and TLAST it arrived with, and in the order it was accepted.
- R2: A beat is written only on a write-clock edge where `s_axis_tvalid` and `s_axis_tready` are both high. `s_axis_tready` is low whenever `wr_level` equals DEPTH.
- R3: `wr_level` (log2(DEPTH)+1 bits) counts the words held in the storage array, as seen from the write clock, and never exceeds DEPTH.
- R4: `wr_afull` is high exactly when DEPTH minus `wr_level` is at or below AFULL_FREE (default DEPTH/2).
- R5: `rd_level` (log2(DEPTH)+1 bits) counts the words held in the storage array, as seen from the read clock. A word already moved into the output register is not counted. `rd_aempty` is high exactly when `rd_level` is at or below AEMPTY_USED (default DEPTH/2).
- R6: In fall-through mode (FALL_THROUGH=1) `m_axis_tvalid` rises with the oldest beat while `m_axis_tready` is low. A beat is consumed only when valid and ready are both high. While stalled, valid and the beat stay unchanged.
- R7: With fall-through and OUT_REG=1 a register sits in front of the port and can hold one beat. With no reads, DEPTH+1 beats are accepted before `s_axis_tready` stays low.
- R8: In request mode (FALL_THROUGH=0) `m_axis_tvalid` stays low while `m_axis_tready` is low and nothing has been fetched. A cycle with `m_axis_tready` high and a non-empty array fetches the oldest beat, which shows with valid high on the next read-clock cycle. OUT_REG has no effect in this mode.
- R9: After reset each side shows an empty FIFO: `s_axis_tready` high, `wr_level` 0, `wr_afull` low, `m_axis_tvalid` low, `rd_level` 0, `rd_aempty` high.
- R10: Each pointer is passed across in Gray code, and its registered Gray value changes in at most one bit per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Receive-side clock |
| wr_rst | input | 1 | Receive-side synchronous reset, active high |
| s_axis_tdata | input | DATA_W | Incoming data |
| s_axis_tuser | input | USER_W | Incoming sideband |
| s_axis_tkeep | input | DATA_W/8 | Incoming byte qualifiers |
| s_axis_tlast | input | 1 | Incoming end-of-packet marker |
| s_axis_tvalid | input | 1 | Incoming beat present |
| s_axis_tready | output | 1 | FIFO can take a beat |
| wr_afull | output | 1 | Free words at or below AFULL_FREE |
| wr_level | output | log2(DEPTH)+1 | Stored words, write-clock view |
| rd_clk | input | 1 | Transmit-side clock |
| rd_rst | input | 1 | Transmit-side synchronous reset, active high |
| m_axis_tdata | output | DATA_W | Outgoing data |
| m_axis_tuser | output | USER_W | Outgoing sideband |
| m_axis_tkeep | output | DATA_W/8 | Outgoing byte qualifiers |
| m_axis_tlast | output | 1 | Outgoing end-of-packet marker |
| m_axis_tvalid | output | 1 | Outgoing beat present |
| m_axis_tready | input | 1 | Sink takes the beat / fetch request |
| rd_aempty | output | 1 | Stored words at or below AEMPTY_USED |
| rd_level | output | log2(DEPTH)+1 | Stored words, read-clock view |

## Verification
The bench builds two copies. The main one has DEPTH=16, AFULL_FREE=3, AEMPTY_USED=5, fall-through and the output register. Its offsets are away from the default, so both flags are seen switching at non-midpoint levels. With the output register in place, the DEPTH+1 acceptance count and the data order across long random stall patterns on two unrelated clocks can be checked. A second copy with DEPTH=4 in request mode checks the one-cycle fetch latency, the idle output while ready is low, and the hold of a fetched beat under stall.

// File: rtl/axcf_pkg.sv
package axcf_pkg;
  typedef enum logic [1:0] {
    OUT_COMB = 2'd0,
    OUT_PIPE = 2'd1,
    OUT_REQ  = 2'd2
  } axcf_out_e;

  function automatic axcf_out_e pick_out(input bit fall_through, input bit out_reg);
    if (!fall_through) return OUT_REQ;
    if (out_reg)       return OUT_PIPE;
    return OUT_COMB;
  endfunction
endpackage

// File: rtl/axcf_sync.sv
module axcf_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/axcf_wr_ctrl.sv
module axcf_wr_ctrl #(
  parameter int DEPTH      = 16,
  parameter int AFULL_FREE = DEPTH / 2,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW:0]   rgray_sync,
  output logic          ready,
  output logic          wen,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic [AW:0]   level,
  output logic          afull
);
  localparam logic [AW:0] DEPTH_L = (AW + 1)'(DEPTH);
  localparam logic [AW:0] AF_L    = (AW + 1)'(AFULL_FREE);

  logic [AW:0] wbin, wbin_nxt, rbin_s;

  always_comb begin
    rbin_s[AW] = rgray_sync[AW];
    for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_sync[i];
  end

  assign level    = wbin - rbin_s;
  assign ready    = !rst && (level != DEPTH_L);
  assign wen      = push && ready;
  assign wbin_nxt = wbin + (AW + 1)'(1);
  assign waddr    = wbin[AW-1:0];
  assign afull    = (DEPTH_L - level) <= AF_L;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wen) begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wen |-> (level < DEPTH_L)); // R2
  AST_WR_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    level <= DEPTH_L); // R3
  AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1); // R10
endmodule

// File: rtl/axcf_rd_ctrl.sv
module axcf_rd_ctrl #(
  parameter int DEPTH       = 16,
  parameter int AEMPTY_USED = DEPTH / 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic [AW:0]   wgray_sync,
  output logic          empty,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [AW:0]   level,
  output logic          aempty
);
  localparam logic [AW:0] DEPTH_L = (AW + 1)'(DEPTH);
  localparam logic [AW:0] AE_L    = (AW + 1)'(AEMPTY_USED);

  logic [AW:0] rbin, rbin_nxt, wbin_s;

  always_comb begin
    wbin_s[AW] = wgray_sync[AW];
    for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_sync[i];
  end

  assign level    = wbin_s - rbin;
  assign empty    = (level == '0);
  assign raddr    = rbin[AW-1:0];
  assign rbin_nxt = rbin + (AW + 1)'(1);
  assign aempty   = level <= AE_L;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop) begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R5
  AST_RD_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    level <= DEPTH_L); // R5
  AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1); // R10
endmodule

// File: rtl/axcf_mem.sv
module axcf_mem #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (wen) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/axcf_out_stage.sv
module axcf_out_stage
  import axcf_pkg::*;
#(
  parameter int W                = 8,
  parameter axcf_out_e KIND      = OUT_PIPE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] head,
  input  logic         empty,
  output logic         pop,
  output logic [W-1:0] m_data,
  output logic         m_valid,
  input  logic         m_ready
);
  generate
    if (KIND == OUT_COMB) begin : g_comb
      assign m_valid = !empty;
      assign m_data  = head;
      assign pop     = m_valid && m_ready;
    end else if (KIND == OUT_PIPE) begin : g_pipe
      logic         v;
      logic [W-1:0] d;
      logic         open;
      assign open    = !v || m_ready;
      assign pop     = open && !empty;
      assign m_valid = v;
      assign m_data  = d;
      always_ff @(posedge clk) begin
        if (rst) begin
          v <= 1'b0;
          d <= '0;
        end else begin
          if (open) v <= !empty;
          if (pop)  d <= head;
        end
      end
    end else begin : g_req
      logic         v;
      logic [W-1:0] d;
      assign pop     = m_ready && !empty;
      assign m_valid = v;
      assign m_data  = d;
      always_ff @(posedge clk) begin
        if (rst) begin
          v <= 1'b0;
          d <= '0;
        end else begin
          if (m_ready) v <= !empty;
          if (pop)     d <= head;
        end
      end
    end
  endgenerate

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R6
endmodule

// File: rtl/axis_cdc_fifo.sv
module axis_cdc_fifo
  import axcf_pkg::*;
#(
  parameter int DATA_W       = 64,
  parameter int USER_W       = 16,
  parameter int DEPTH        = 16,
  parameter int AFULL_FREE   = DEPTH / 2,
  parameter int AEMPTY_USED  = DEPTH / 2,
  parameter bit FALL_THROUGH = 1'b1,
  parameter bit OUT_REG      = 1'b1,
  localparam int KEEP_W      = DATA_W / 8,
  localparam int AW          = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic [DATA_W-1:0] s_axis_tdata,
  input  logic [USER_W-1:0] s_axis_tuser,
  input  logic [KEEP_W-1:0] s_axis_tkeep,
  input  logic              s_axis_tlast,
  input  logic              s_axis_tvalid,
  output logic              s_axis_tready,
  output logic              wr_afull,
  output logic [AW:0]       wr_level,
  input  logic              rd_clk,
  input  logic              rd_rst,
  output logic [DATA_W-1:0] m_axis_tdata,
  output logic [USER_W-1:0] m_axis_tuser,
  output logic [KEEP_W-1:0] m_axis_tkeep,
  output logic              m_axis_tlast,
  output logic              m_axis_tvalid,
  input  logic              m_axis_tready,
  output logic              rd_aempty,
  output logic [AW:0]       rd_level
);
  localparam int WORD_W = DATA_W + USER_W + KEEP_W + 1;
  localparam axcf_out_e KIND = pick_out(FALL_THROUGH, OUT_REG);

  logic [WORD_W-1:0] wword, head, oword;
  logic [AW:0]       wgray, rgray, wgray_rd, rgray_wr;
  logic [AW-1:0]     waddr, raddr;
  logic              wen, pop, empty;

  assign wword = {s_axis_tlast, s_axis_tkeep, s_axis_tuser, s_axis_tdata};

  axcf_wr_ctrl #(.DEPTH(DEPTH), .AFULL_FREE(AFULL_FREE)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .push(s_axis_tvalid), .rgray_sync(rgray_wr),
    .ready(s_axis_tready), .wen(wen), .waddr(waddr), .wgray(wgray),
    .level(wr_level), .afull(wr_afull)
  );

  axcf_sync #(.W(AW + 1)) u_sync_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_wr)
  );

  axcf_sync #(.W(AW + 1)) u_sync_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_rd)
  );

  axcf_mem #(.W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .wclk(wr_clk), .wen(wen), .waddr(waddr), .wdata(wword),
    .raddr(raddr), .rdata(head)
  );

  axcf_rd_ctrl #(.DEPTH(DEPTH), .AEMPTY_USED(AEMPTY_USED)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .pop(pop), .wgray_sync(wgray_rd),
    .empty(empty), .raddr(raddr), .rgray(rgray), .level(rd_level),
    .aempty(rd_aempty)
  );

  axcf_out_stage #(.W(WORD_W), .KIND(KIND)) u_out (
    .clk(rd_clk), .rst(rd_rst), .head(head), .empty(empty), .pop(pop),
    .m_data(oword), .m_valid(m_axis_tvalid), .m_ready(m_axis_tready)
  );

  assign {m_axis_tlast, m_axis_tkeep, m_axis_tuser, m_axis_tdata} = oword;

  AST_WR_BLOCK_FULL: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_level == (AW + 1)'(DEPTH)) |-> !s_axis_tready); // R2
  AST_RD_IDLE_EMPTY: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (FALL_THROUGH && !OUT_REG && rd_level == '0) |-> !m_axis_tvalid); // R6
endmodule

// File: tb/axis_cdc_fifo_test.sv
module axis_cdc_fifo_test;
  localparam int DW = 32, UW = 8, KW = 4, WW = 45;
  localparam int TOTAL = 3017;

  logic wr_clk = 0, rd_clk = 0, wr_rst = 1, rd_rst = 1;
  always #10 wr_clk = ~wr_clk;
  always #17 rd_clk = ~rd_clk;

  logic [DW-1:0] s_tdata;  logic [UW-1:0] s_tuser; logic [KW-1:0] s_tkeep;
  logic s_tlast = 0, s_tvalid = 0, s_tready, wr_afull, rd_aempty, m_tready = 0;
  logic [DW-1:0] m_tdata;  logic [UW-1:0] m_tuser; logic [KW-1:0] m_tkeep;
  logic m_tlast, m_tvalid;
  logic [4:0] wr_level, rd_level;

  logic [DW-1:0] n_sdata;  logic [UW-1:0] n_suser; logic [KW-1:0] n_skeep;
  logic n_slast = 0, n_svalid = 0, n_sready, n_afull, n_aempty, n_mready = 0;
  logic [DW-1:0] n_mdata;  logic [UW-1:0] n_muser; logic [KW-1:0] n_mkeep;
  logic n_mlast, n_mvalid;
  logic [2:0] n_wlevel, n_rlevel;

  axis_cdc_fifo #(.DATA_W(DW), .USER_W(UW), .DEPTH(16), .AFULL_FREE(3),
                  .AEMPTY_USED(5), .FALL_THROUGH(1), .OUT_REG(1)) uut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .s_axis_tdata(s_tdata), .s_axis_tuser(s_tuser),
    .s_axis_tkeep(s_tkeep), .s_axis_tlast(s_tlast), .s_axis_tvalid(s_tvalid),
    .s_axis_tready(s_tready), .wr_afull(wr_afull), .wr_level(wr_level),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .m_axis_tdata(m_tdata), .m_axis_tuser(m_tuser),
    .m_axis_tkeep(m_tkeep), .m_axis_tlast(m_tlast), .m_axis_tvalid(m_tvalid),
    .m_axis_tready(m_tready), .rd_aempty(rd_aempty), .rd_level(rd_level));

  axis_cdc_fifo #(.DATA_W(DW), .USER_W(UW), .DEPTH(4), .FALL_THROUGH(0),
                  .OUT_REG(1)) uut_std (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .s_axis_tdata(n_sdata), .s_axis_tuser(n_suser),
    .s_axis_tkeep(n_skeep), .s_axis_tlast(n_slast), .s_axis_tvalid(n_svalid),
    .s_axis_tready(n_sready), .wr_afull(n_afull), .wr_level(n_wlevel),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .m_axis_tdata(n_mdata), .m_axis_tuser(n_muser),
    .m_axis_tkeep(n_mkeep), .m_axis_tlast(n_mlast), .m_axis_tvalid(n_mvalid),
    .m_axis_tready(n_mready), .rd_aempty(n_aempty), .rd_level(n_rlevel));

  int vectors = 0, misses = 0, widx = 0, ridx = 0;
  bit done = 0;

  function automatic logic [WW-1:0] beat(input int n);
    logic [DW-1:0] d = DW'(n) * 32'h9E3779B1 ^ 32'h1234_5678;
    logic [UW-1:0] u = UW'(n) ^ 8'h5A;
    logic [KW-1:0] k = (n % 4 == 3) ? 4'h7 : 4'hF;
    logic          l = (n % 5 == 4);
    return {l, k, u, d};
  endfunction

  function automatic bit afull_exp(input logic [4:0] lvl);
    return (16 - int'(lvl)) <= 3;
  endfunction

  function automatic bit aempty_exp(input logic [4:0] lvl);
    return int'(lvl) <= 5;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_writer(input int upto, input int pct);
    while (widx < upto) begin
      @(negedge wr_clk);
      s_tvalid = ($urandom % 100) < pct;
      {s_tlast, s_tkeep, s_tuser, s_tdata} = beat(widx);
      #1;
      chk("R4 afull", 64'(wr_afull), 64'(afull_exp(wr_level)));
      if (s_tvalid && s_tready) widx++;
    end
    @(negedge wr_clk);
    s_tvalid = 0;
  endtask

  task automatic run_reader(input int upto, input int pct);
    while (ridx < upto) begin
      @(negedge rd_clk);
      m_tready = ($urandom % 100) < pct;
      #1;
      chk("R5 aempty", 64'(rd_aempty), 64'(aempty_exp(rd_level)));
      if (m_tvalid && m_tready) begin
        chk("R1 beat order", 64'({m_tlast, m_tkeep, m_tuser, m_tdata}), 64'(beat(ridx)));
        ridx++;
      end
    end
    @(negedge rd_clk);
    m_tready = 0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    {s_tlast, s_tkeep, s_tuser, s_tdata} = '0;
    {n_slast, n_skeep, n_suser, n_sdata} = '0;
    repeat (6) @(posedge rd_clk);
    @(negedge wr_clk); wr_rst = 0;
    @(negedge rd_clk); rd_rst = 0;
    repeat (3) @(negedge wr_clk);
    // R9 reset state
    chk("R9 s_tready", 64'(s_tready), 64'd1);
    chk("R9 wr_level", 64'(wr_level), 64'd0);
    chk("R9 wr_afull", 64'(wr_afull), 64'd0);
    @(negedge rd_clk);
    chk("R9 m_tvalid", 64'(m_tvalid), 64'd0);
    chk("R9 rd_level", 64'(rd_level), 64'd0);
    chk("R9 rd_aempty", 64'(rd_aempty), 64'd1);

    // R7 fill with no reads: DEPTH+1 accepted
    for (int c = 0; c < 80; c++) begin
      @(negedge wr_clk);
      s_tvalid = 1;
      {s_tlast, s_tkeep, s_tuser, s_tdata} = beat(widx);
      #1;
      if (s_tready) widx++;
    end
    @(negedge wr_clk); s_tvalid = 0;
    chk("R7 accepted count", 64'(widx), 64'd17);
    chk("R2 s_tready full", 64'(s_tready), 64'd0);
    chk("R3 wr_level full", 64'(wr_level), 64'd16);
    chk("R4 wr_afull full", 64'(wr_afull), 64'd1);
    repeat (4) @(negedge rd_clk);
    chk("R5 rd_level full", 64'(rd_level), 64'd16);
    chk("R5 rd_aempty full", 64'(rd_aempty), 64'd0);
    chk("R6 valid without ready", 64'(m_tvalid), 64'd1);
    chk("R6 head beat", 64'({m_tlast, m_tkeep, m_tuser, m_tdata}), 64'(beat(0)));

    run_reader(17, 50);
    repeat (6) @(negedge rd_clk);
    chk("R5 rd_level drained", 64'(rd_level), 64'd0);
    chk("R5 rd_aempty drained", 64'(rd_aempty), 64'd1);
    chk("R6 idle valid", 64'(m_tvalid), 64'd0);
    repeat (4) @(negedge wr_clk);
    chk("R3 wr_level drained", 64'(wr_level), 64'd0);
    chk("R2 s_tready drained", 64'(s_tready), 64'd1);

    // R1 random traffic on both sides
    fork
      run_writer(TOTAL, 70);
      run_reader(TOTAL, 60);
    join
    repeat (6) @(negedge rd_clk);
    chk("R1 all beats out", 64'(ridx), 64'(TOTAL));
    chk("R5 rd_level end", 64'(rd_level), 64'd0);

    // R8 request mode on the second copy
    for (int c = 0; c < 2; c++) begin
      @(negedge wr_clk);
      n_svalid = 1;
      {n_slast, n_skeep, n_suser, n_sdata} = beat(100 + c);
    end
    @(negedge wr_clk); n_svalid = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge rd_clk);
      chk("R8 idle without request", 64'(n_mvalid), 64'd0);
    end
    chk("R8 rd_level before fetch", 64'(n_rlevel), 64'd2);
    n_mready = 1;
    @(negedge rd_clk); n_mready = 0;
    chk("R8 fetch latency valid", 64'(n_mvalid), 64'd1);
    chk("R8 fetched beat", 64'({n_mlast, n_mkeep, n_muser, n_mdata}), 64'(beat(100)));
    chk("R8 rd_level after fetch", 64'(n_rlevel), 64'd1);
    @(negedge rd_clk);
    chk("R8 stall hold", 64'({n_mlast, n_mkeep, n_muser, n_mdata}), 64'(beat(100)));
    n_mready = 1;
    @(negedge rd_clk);
    chk("R8 next beat", 64'({n_mlast, n_mkeep, n_muser, n_mdata}), 64'(beat(101)));
    @(negedge rd_clk); n_mready = 0;
    chk("R8 empty after consume", 64'(n_mvalid), 64'd0);

    done = 1;
    summary();
  end
endmodule